// File: doc/BRIEF.md
# Cascadable Dual 16-bit Timer Pair

This block holds two 16-bit up-counting timers behind one 32-bit register port. A cascade bit in the shared global register selects how they work. With the bit clear, each timer has its own mode, reference, capture register, capture pin and event bits. With the bit set, the pair becomes a single 32-bit timer. The first (low) timer supplies the low-order half and the second (high) timer supplies the high-order half. The mode, the capture pin, the run bit and the event bits of the high timer then govern the whole counter. The low timer's copies are ignored.

Each 32-bit register places the low timer in data bits [15:0] and the high timer in bits [31:16]. A cascaded value therefore reads as one word. Writes carry a two-bit lane strobe, one bit for each 16-bit half. The port has no back-pressure: a write takes effect at the clock edge on which `bus_wr` is high, and read data is combinational from `bus_addr`. Counting advances only on cycles where `tick_en` is high. Changing the cascade bit while a timer runs is not supported.

Register map (word address): 0 global (bit0 run low timer, bit1 run high timer, bit2 cascade); 1 mode; 2 reference; 3 counter; 4 capture (read only); 5 event. Mode bits within each lane: bit0 restart on reference, bit1 capture enable, bit2 capture on falling edge (else rising), bit3 reference interrupt enable, bit4 capture interrupt enable. Event bits within each lane: bit0 reference hit, bit1 capture.

Top module: `ctp_timer_pair`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: With cascade clear, a write of 1 to a run bit makes that timer count up by one on each cycle with `tick_en` high. It wraps from 0xFFFF to 0x0000, and a wrap never advances the other timer.
- R3: With cascade set, the low half counts on every `tick_en` cycle while the high timer's run bit (bit1) is set. The high half counts only on a cycle where the low half goes from 0xFFFF to 0x0000. The 32-bit value wraps to zero, and the low run bit alone does not start counting.
- R4: A counter holds its value on cycles where `tick_en` is low or its run bit is clear.
- R5: One write to the global register starts or stops both timers on the same edge, so both advance by the same number of ticks.
- R6: On a counting cycle where the counter equals the reference, the reference event bit (lane bit0) sets. If the restart mode bit (bit0) is set, the counter goes to zero instead of incrementing. In cascade this uses the full 32-bit compare and the high timer's mode, and the low timer's mode has no effect.
- R7: A selected edge on a capture pin, with capture enable (mode bit1) set, latches the counter into the capture register and sets the capture event bit (lane bit1). Mode bit2 chooses the falling edge over the rising edge. In cascade only the high timer's pin triggers, and it latches all 32 bits at once. The low timer's pin is then ignored.
- R8: Event bits clear when 1 is written to them with the lane strobe set, and are otherwise sticky. In cascade, events appear only in the high lane bits (16 and 17).
- R9: `irq` is high exactly while some event bit is set whose matching interrupt enable (mode bit3 for reference, bit4 for capture) is set in the governing mode.
- R10: With cascade set, a reference or counter write that does not strobe both lanes is ignored. With cascade clear, each lane writes independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_lane | input | 2 | Lane strobe: bit0 data [15:0], bit1 data [31:16] |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tick_en | input | 1 | Count enable for this cycle |
| cap_pin | input | 2 | Capture inputs: bit0 low timer, bit1 high timer |
| irq | output | 1 | Combined interrupt |

## Verification
Counting is swept over start values just below and at the 16-bit wrap, with tick counts of one to several. In split mode this shows that the lanes do not carry into each other. In cascade it shows that the carry arrives in exactly the wrap cycle. Restart sweeps over every tick count up to two full periods use different references per lane, which separates lane-local compare from 32-bit compare. Capture runs with both edge selections and with a value that has an all-ones low half. Writing a mode or strobe pattern that only the low timer would honour checks that cascade hands ownership to the high timer.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
  localparam int ADDR_W = 3;
  localparam int MODE_W = 5;

  localparam logic [ADDR_W-1:0] A_GLB = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_REF = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAP = 3'd4;
  localparam logic [ADDR_W-1:0] A_EVT = 3'd5;

  // packed: last field is bit 0
  typedef struct packed {
    logic cap_ie;
    logic ref_ie;
    logic cap_fall;
    logic cap_en;
    logic restart;
  } mode_t;
endpackage

// File: rtl/ctp_sync_edge.sv
module ctp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic hit
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              level;

  assign level = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= level;
    end
  end

  assign hit = fall_sel ? (prev_q & ~level) : (~prev_q & level);
endmodule

// File: rtl/ctp_half_counter.sv
module ctp_half_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clear,
  input  logic         tick,
  output logic [W-1:0] value,
  output logic         all_ones
);
  logic [W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) val_q <= '0;
    else if (load) val_q <= load_val;
    else if (clear) val_q <= '0;
    else if (tick) val_q <= val_q + 1'b1;
  end

  assign value    = val_q;
  assign all_ones = &val_q;
endmodule

// File: rtl/ctp_timer_pair.sv
module ctp_timer_pair
  import ctp_pkg::*;
#(
  parameter int HALF_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [1:0]            bus_lane,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [2*HALF_W-1:0]   bus_wdata,
  output logic [2*HALF_W-1:0]   bus_rdata,
  input  logic                  tick_en,
  input  logic [1:0]            cap_pin,
  output logic                  irq
);
  localparam int FULL_W = 2 * HALF_W;

  logic              casc_q;
  logic [1:0]        run_q;
  logic [HALF_W-1:0] mode_q [2];
  logic [HALF_W-1:0] ref_q  [2];
  logic [HALF_W-1:0] cap_q  [2];
  logic [HALF_W-1:0] cnt    [2];
  logic [HALF_W-1:0] wlane  [2];
  logic [HALF_W-1:0] ev_lane [2];
  logic [1:0]        ev_ref_q, ev_cap_q;
  logic [1:0]        ones, tick, clr, ref_hit, cap_hit, edge_hit, lane_irq;
  logic [1:0]        wr_mode, wr_ref, wr_cnt, wr_ev, match;
  mode_t             md [2];
  logic              lane_ok, wr_glb, tick_lo, match_full;
  logic [HALF_W-1:0] cnt_lo, cnt_hi;
  logic              clr_hi;

  assign wlane[0] = bus_wdata[HALF_W-1:0];
  assign wlane[1] = bus_wdata[FULL_W-1:HALF_W];
  assign lane_ok  = !casc_q || (bus_lane == 2'b11);
  assign wr_glb   = bus_wr && (bus_addr == A_GLB);

  // global register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      casc_q <= 1'b0;
    end else if (wr_glb) begin
      run_q  <= bus_wdata[1:0];
      casc_q <= bus_wdata[2];
    end
  end

  assign tick_lo    = tick_en && run_q[1];
  assign match_full = ({cnt[1], cnt[0]} == {ref_q[1], ref_q[0]});

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign md[g]      = mode_t'(mode_q[g][MODE_W-1:0]);
    assign wr_mode[g] = bus_wr && (bus_addr == A_MODE) && bus_lane[g];
    assign wr_ref[g]  = bus_wr && (bus_addr == A_REF) && bus_lane[g] && lane_ok;
    assign wr_cnt[g]  = bus_wr && (bus_addr == A_CNT) && bus_lane[g] && lane_ok;
    assign wr_ev[g]   = bus_wr && (bus_addr == A_EVT) && bus_lane[g];
    assign match[g]   = (cnt[g] == ref_q[g]);
    assign ev_lane[g] = {{(HALF_W-2){1'b0}}, ev_cap_q[g], ev_ref_q[g]};
    assign lane_irq[g] = (ev_ref_q[g] & md[g].ref_ie) | (ev_cap_q[g] & md[g].cap_ie);

    ctp_half_counter #(.W(HALF_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_cnt[g]),
      .load_val (wlane[g]),
      .clear    (clr[g]),
      .tick     (tick[g]),
      .value    (cnt[g]),
      .all_ones (ones[g])
    );

    ctp_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (cap_pin[g]),
      .fall_sel (md[g].cap_fall),
      .hit      (edge_hit[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode_q[g]   <= '0;
        ref_q[g]    <= '0;
        ev_ref_q[g] <= 1'b0;
        ev_cap_q[g] <= 1'b0;
      end else begin
        if (wr_mode[g]) mode_q[g] <= wlane[g];
        if (wr_ref[g])  ref_q[g]  <= wlane[g];
        ev_ref_q[g] <= ref_hit[g] | (ev_ref_q[g] & ~(wr_ev[g] & wlane[g][0]));
        ev_cap_q[g] <= cap_hit[g] | (ev_cap_q[g] & ~(wr_ev[g] & wlane[g][1]));
      end
    end
  end

  // tick, compare and restart steering
  always_comb begin
    if (casc_q) begin
      tick[0]    = tick_lo;
      tick[1]    = tick_lo && ones[0];
      ref_hit[0] = 1'b0;
      ref_hit[1] = tick_lo && match_full;
      clr[0]     = ref_hit[1] && md[1].restart;
      clr[1]     = ref_hit[1] && md[1].restart;
      cap_hit[0] = 1'b0;
    end else begin
      tick[0]    = tick_en && run_q[0];
      tick[1]    = tick_en && run_q[1];
      ref_hit[0] = tick[0] && match[0];
      ref_hit[1] = tick[1] && match[1];
      clr[0]     = ref_hit[0] && md[0].restart;
      clr[1]     = ref_hit[1] && md[1].restart;
      cap_hit[0] = edge_hit[0] && md[0].cap_en;
    end
    cap_hit[1] = edge_hit[1] && md[1].cap_en;
  end

  // capture latch: both halves on the same edge when cascaded
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q[0] <= '0;
      cap_q[1] <= '0;
    end else begin
      if (cap_hit[0] || (casc_q && cap_hit[1])) cap_q[0] <= cnt[0];
      if (cap_hit[1]) cap_q[1] <= cnt[1];
    end
  end

  always_comb begin
    case (bus_addr)
      A_GLB:   bus_rdata = {{(FULL_W-3){1'b0}}, casc_q, run_q};
      A_MODE:  bus_rdata = {mode_q[1], mode_q[0]};
      A_REF:   bus_rdata = {ref_q[1], ref_q[0]};
      A_CNT:   bus_rdata = {cnt[1], cnt[0]};
      A_CAP:   bus_rdata = {cap_q[1], cap_q[0]};
      A_EVT:   bus_rdata = {ev_lane[1], ev_lane[0]};
      default: bus_rdata = '0;
    endcase
  end

  assign irq = lane_irq[1] | (lane_irq[0] & ~casc_q);

  assign cnt_lo = cnt[0];
  assign cnt_hi = cnt[1];
  assign clr_hi = clr[1];
endmodule

// File: rtl/ctp_timer_pair_chk.sv
module ctp_timer_pair_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         casc_q,
  input logic [1:0]   run_q,
  input logic         tick_en,
  input logic         bus_wr,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] cnt_hi,
  input logic         clr_hi,
  input logic [1:0]   ev_ref_q,
  input logic [1:0]   ev_cap_q,
  input logic         irq
);
  // R3
  carry_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    casc_q && tick_en && run_q[1] && (&cnt_lo) && !bus_wr && !clr_hi
    |=> cnt_hi == W'($past(cnt_hi) + 1'b1));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !bus_wr |=> $stable(cnt_lo) && $stable(cnt_hi));

  // R2
  split_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !casc_q && !run_q[1] && !bus_wr |=> $stable(cnt_hi));

  // R8
  low_event_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ev_ref_q[0]) || $rose(ev_cap_q[0])) |-> !$past(casc_q));

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((|ev_ref_q) || (|ev_cap_q)));
endmodule

bind ctp_timer_pair ctp_timer_pair_chk #(.W(HALF_W)) u_chk (.*);

// File: tb/ctp_timer_pair_test.sv
module ctp_timer_pair_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_lane = 2'b00;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_en = 1'b0;
  logic [1:0]  cap_pin = 2'b00;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctp_timer_pair uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_lane(bus_lane),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .cap_pin(cap_pin), .irq(irq)
  );

  localparam logic [2:0] GLB = 3'd0, MODE = 3'd1, REFR = 3'd2, CNT = 3'd3, CAP = 3'd4, EVT = 3'd5;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [1:0] ln, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_lane = ln; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_lane = 2'b00;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic pulse(input int idx, input bit rise_only);
    @(negedge clk);
    cap_pin[idx] = 1'b1;
    repeat (5) @(negedge clk);
    if (!rise_only) begin
      cap_pin[idx] = 1'b0;
      repeat (5) @(negedge clk);
    end
  endtask

  // runs n counted ticks with run word g, stopping afterwards with stop word s
  task automatic run_n(input logic [31:0] g, input logic [31:0] s, input int n);
    wr(GLB, 2'b11, g);
    ticks(n);
    wr(GLB, 2'b11, s);
  endtask

  function automatic logic [31:0] step_rst(input logic [31:0] s, input logic [31:0] r, input int n);
    logic [31:0] v = s;
    for (int k = 0; k < n; k++) v = (v == r) ? 32'd0 : v + 32'd1;
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [15:0] sa [3];
    logic [15:0] sb [2];
    logic [31:0] sc [4];
    sa = '{16'hFFFD, 16'hFFFF, 16'h1234};
    sb = '{16'h0000, 16'hFFFE};
    sc = '{32'h0000FFFE, 32'h0001FFFF, 32'hFFFFFFFD, 32'h12345678};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk($sformatf("R1 reg %0d", a), d, 32'h0);
    end
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // R2 / R5 split counting, one global write starts and stops both
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 2; j++)
        for (int n = 1; n <= 5; n++) begin
          wr(CNT, 2'b11, {sb[j], sa[i]});
          run_n(32'h3, 32'h0, n);
          rd(CNT, d);
          chk("R2 R5 split count", d, {16'(sb[j] + 16'(n)), 16'(sa[i] + 16'(n))});
        end

    // R4 run bit clear holds high timer; tick_en low holds both
    wr(CNT, 2'b11, 32'h0005FFFF);
    run_n(32'h1, 32'h0, 3);
    rd(CNT, d);
    chk("R4 R2 low only running", d, 32'h00050002);
    wr(GLB, 2'b11, 32'h3);
    repeat (10) @(negedge clk);
    wr(GLB, 2'b11, 32'h0);
    rd(CNT, d);
    chk("R4 tick_en low", d, 32'h00050002);

    // R3 cascaded counting sweep
    wr(GLB, 2'b11, 32'h4);
    for (int i = 0; i < 4; i++)
      for (int n = 1; n <= 6; n++) begin
        wr(CNT, 2'b11, sc[i]);
        run_n(32'h6, 32'h4, n);
        rd(CNT, d);
        chk("R3 cascade count", d, sc[i] + 32'(n));
      end
    wr(CNT, 2'b11, 32'h0000FFFF);
    run_n(32'h5, 32'h4, 4);
    rd(CNT, d);
    chk("R3 low run bit ignored", d, 32'h0000FFFF);

    // R10 partial writes in cascade
    wr(CNT, 2'b11, 32'h11112222);
    wr(CNT, 2'b01, 32'h0000AAAA);
    rd(CNT, d);
    chk("R10 cascade partial cnt", d, 32'h11112222);
    wr(REFR, 2'b11, 32'h01020304);
    wr(REFR, 2'b10, 32'hBBBB0000);
    rd(REFR, d);
    chk("R10 cascade partial ref", d, 32'h01020304);
    wr(GLB, 2'b11, 32'h0);
    wr(CNT, 2'b01, 32'h0000AAAA);
    rd(CNT, d);
    chk("R10 split lane write", d, 32'h1111AAAA);

    // R6 split restart sweep
    wr(MODE, 2'b11, 32'h00010001);
    wr(REFR, 2'b11, 32'h00030005);
    for (int n = 1; n <= 12; n++) begin
      wr(CNT, 2'b11, 32'h0);
      run_n(32'h3, 32'h0, n);
      rd(CNT, d);
      chk("R6 split restart", d, {16'(n % 4), 16'(n % 6)});
    end

    // R6 cascaded restart on 32-bit compare
    wr(GLB, 2'b11, 32'h4);
    wr(MODE, 2'b11, 32'h00010000);
    wr(REFR, 2'b11, 32'h00010002);
    for (int i = 0; i < 2; i++)
      for (int n = 1; n <= 8; n++) begin
        d = (i == 0) ? 32'h00010000 : 32'h0000FFFE;
        wr(CNT, 2'b11, d);
        run_n(32'h6, 32'h4, n);
        rd(CNT, d);
        chk("R6 cascade restart", d, step_rst((i == 0) ? 32'h00010000 : 32'h0000FFFE, 32'h00010002, n));
      end

    // R6 R8 low mode ignored in cascade
    wr(EVT, 2'b11, 32'h00030003);
    wr(MODE, 2'b11, 32'h00000009);
    wr(REFR, 2'b11, 32'h00000003);
    wr(CNT, 2'b11, 32'h0);
    run_n(32'h6, 32'h4, 6);
    rd(CNT, d);
    chk("R6 low mode ignored", d, 32'h6);
    rd(EVT, d);
    chk("R8 cascade event lane", d, 32'h00010000);
    chk("R9 no irq from low mode", {31'd0, irq}, 32'h0);

    // R8 R9 split events and W1C
    wr(GLB, 2'b11, 32'h0);
    wr(EVT, 2'b11, 32'h00030003);
    rd(EVT, d);
    chk("R8 cleared", d, 32'h0);
    wr(MODE, 2'b11, 32'h00000008);
    wr(REFR, 2'b11, 32'h00000002);
    wr(CNT, 2'b11, 32'h0);
    run_n(32'h1, 32'h0, 3);
    rd(EVT, d);
    chk("R6 split ref event", d, 32'h1);
    chk("R9 irq ref", {31'd0, irq}, 32'h1);
    wr(EVT, 2'b01, 32'h2);
    rd(EVT, d);
    chk("R8 other bit write keeps", d, 32'h1);
    wr(EVT, 2'b10, 32'h1);
    rd(EVT, d);
    chk("R8 other lane write keeps", d, 32'h1);
    wr(EVT, 2'b01, 32'h1);
    rd(EVT, d);
    chk("R8 w1c", d, 32'h0);
    chk("R9 irq drops", {31'd0, irq}, 32'h0);

    // R9 cascaded irq through high enable
    wr(GLB, 2'b11, 32'h4);
    wr(MODE, 2'b11, 32'h00080000);
    wr(REFR, 2'b11, 32'h00010001);
    wr(CNT, 2'b11, 32'h0000FFFF);
    run_n(32'h6, 32'h4, 3);
    rd(EVT, d);
    chk("R8 cascade ref event", d, 32'h00010000);
    chk("R9 cascade irq", {31'd0, irq}, 32'h1);
    rd(CNT, d);
    chk("R3 carry then no restart", d, 32'h00010002);
    wr(EVT, 2'b11, 32'h00030003);

    // R7 split capture, both edge selections
    wr(GLB, 2'b11, 32'h0);
    wr(MODE, 2'b11, 32'h00060012);
    wr(CNT, 2'b11, 32'hBBBBAAAA);
    pulse(0, 1'b0);
    rd(CAP, d);
    chk("R7 rising capture low", d, 32'h0000AAAA);
    rd(EVT, d);
    chk("R7 capture event low", d, 32'h2);
    chk("R9 cap irq", {31'd0, irq}, 32'h1);
    pulse(1, 1'b1);
    rd(CAP, d);
    chk("R7 rising ignored when falling selected", d, 32'h0000AAAA);
    @(negedge clk);
    cap_pin[1] = 1'b0;
    repeat (5) @(negedge clk);
    rd(CAP, d);
    chk("R7 falling capture high", d, 32'hBBBBAAAA);
    rd(EVT, d);
    chk("R7 capture event high", d, 32'h00020002);
    wr(EVT, 2'b11, 32'h00030003);

    // R7 cascaded capture
    wr(GLB, 2'b11, 32'h4);
    wr(MODE, 2'b11, 32'h00020002);
    wr(CNT, 2'b11, 32'h0001FFFF);
    pulse(0, 1'b0);
    rd(CAP, d);
    chk("R7 low pin ignored in cascade", d, 32'hBBBBAAAA);
    rd(EVT, d);
    chk("R8 no event from low pin", d, 32'h0);
    pulse(1, 1'b0);
    rd(CAP, d);
    chk("R7 cascade 32-bit capture", d, 32'h0001FFFF);
    rd(EVT, d);
    chk("R8 cascade capture event", d, 32'h00020000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule